// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to fifteen interrupt sources for a processor core. It holds them in a pending register and filters them through a per-source mask. It hands the core one request at a time: a 4-bit level, which is the number of the winning source, and an 8-bit trap type. Source numbers, register bit positions, priority levels and trap types all line up. Source n lives in bit n of every per-source register, has priority n, and traps with type 0x10 + n. Bit 0 is never used.

Software reaches the block through a small word-addressed register port. Through it, software can read which sources are waiting, set or clear mask bits, and clear pending bits by writing ones. It can also inject interrupts by writing ones, but only while a force-enable bit in the test-control register is set. When the core acknowledges a level, the matching pending bit drops on the same clock edge. A request that is active in that same cycle keeps the bit pending.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending register is 0, every mask bit for sources 1..15 is 1 (mask reads 0x0000FFFE), the force-enable bit is 0, and the level and trap outputs are 0.
- R2: A request input bit n (1..15) that is high at a clock edge sets pending bit n at that edge. The bit stays set after the request drops, until it is cleared or acknowledged.
- R3: Pending (word address 0) reads every waiting source whatever its mask. Bit 0 and bits 16..31 read 0.
- R4: A mask bit of 1 keeps its source off the level output, and a mask bit of 0 lets it through. Mask is read and written at word address 1; bit 0 is not stored.
- R5: The level output is the highest source number whose pending bit is 1 and whose mask bit is 0. It is 0 when there is no such source.
- R6: The trap output is 0x10 + level when the level is nonzero, and 0x00 otherwise.
- R7: Writing the clear register (word address 2) removes each pending bit whose data bit is 1. Pending bits whose data bit is 0 are kept.
- R8: Writing the force register (word address 3) sets each pending bit whose data bit is 1, but only while test-control bit 19 is 1. While that bit is 0 the write has no effect.
- R9: A cycle with acknowledge high and a nonzero acknowledge level clears that source's pending bit at the clock edge. An acknowledge of level 0 changes nothing.
- R10: A request that is high in the same cycle as a clear or an acknowledge of its own source leaves the pending bit set.
- R11: Writes to address 0 are ignored. Addresses 2, 3, 5, 6 and 7 read 0. Test control (address 4) stores only bit 19 and reads 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 16 | Request inputs; bit n is source n, bit 0 ignored |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from address |
| ack_i | input | 1 | Core acknowledges a level |
| ack_level_i | input | 4 | Level being acknowledged |
| irq_level_o | output | 4 | Winning source number, 0 for none |
| irq_trap_o | output | 8 | Trap type of the winning source |

## Verification
The bench builds the block with its defaults: fifteen sources, a 32-bit data path and the force enable in bit 19. With these values it can reach the extremes of the priority order, source 15 (trap 0x1F) and source 1 (trap 0x11). It can also reach the unused bit 0 and the register bits above the source field. Random mixes of sparse requests, clears, forces, mask and test-control writes, and acknowledges of the current level exercise same-cycle collisions between setting and clearing a bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FRC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TCTL = 3'd4;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NSRC    = 15,
  parameter int DW      = 32,
  parameter int FEN_BIT = 19,
  localparam int VW     = NSRC + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic [VW-1:0]     pend_i,
  output logic [VW-1:0]     mask_o,
  output logic              fen_o,
  output logic [VW-1:0]     clr_o,
  output logic [VW-1:0]     frc_o,
  output logic [DW-1:0]     rdata_o
);
  logic [VW-1:0] mask_q;
  logic          fen_q;
  logic [VW-1:0] wbits;
  logic          unused_wd;

  assign wbits     = {bus_wdata_i[NSRC:1], 1'b0};
  assign unused_wd = ^bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= {{NSRC{1'b1}}, 1'b0};
      fen_q  <= 1'b0;
    end else if (bus_wr_i) begin
      if (bus_addr_i == A_MASK) mask_q <= wbits;
      if (bus_addr_i == A_TCTL) fen_q  <= bus_wdata_i[FEN_BIT];
    end
  end

  assign clr_o  = (bus_wr_i && bus_addr_i == A_CLR) ? wbits : '0;
  assign frc_o  = (bus_wr_i && bus_addr_i == A_FRC && fen_q) ? wbits : '0;
  assign mask_o = mask_q;
  assign fen_o  = fen_q;

  always_comb begin
    rdata_o = '0;
    case (bus_addr_i)
      A_PEND:  rdata_o = DW'(pend_i);
      A_MASK:  rdata_o = DW'(mask_q);
      A_TCTL:  rdata_o[FEN_BIT] = fen_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NSRC = 15,
  localparam int VW  = NSRC + 1,
  localparam int LW  = $clog2(NSRC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] req_i,
  input  logic [VW-1:0] clr_i,
  input  logic [VW-1:0] frc_i,
  input  logic          ack_i,
  input  logic [LW-1:0] ack_level_i,
  output logic [VW-1:0] pend_o
);
  logic unused_b0;
  assign unused_b0 = req_i[0] ^ clr_i[0] ^ frc_i[0];
  assign pend_o[0] = 1'b0;

  for (genvar g = 1; g < VW; g++) begin : g_bit
    logic ack_hit;
    assign ack_hit = ack_i && (ack_level_i == LW'(g));
    // set sources win over clear sources
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[g] <= 1'b0;
      else         pend_o[g] <= (pend_o[g] & ~clr_i[g] & ~ack_hit) | req_i[g] | frc_i[g];
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int NSRC = 15,
  localparam int VW  = NSRC + 1,
  localparam int LW  = $clog2(NSRC + 1)
) (
  input  logic [VW-1:0] pend_i,
  input  logic [VW-1:0] mask_i,
  output logic [LW-1:0] level_o
);
  logic [VW-1:0] active;
  logic          unused_a0;
  assign active    = pend_i & ~mask_i;
  assign unused_a0 = active[0];

  always_comb begin
    level_o = '0;
    for (int i = 1; i < VW; i++)
      if (active[i]) level_o = LW'(i);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC            = 15,
  parameter int DW              = 32,
  parameter int FEN_BIT         = 19,
  parameter int TW              = 8,
  parameter logic [7:0] TRAP_BASE = 8'h10,
  localparam int VW             = NSRC + 1,
  localparam int LW             = $clog2(NSRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VW-1:0]     src_req_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              ack_i,
  input  logic [LW-1:0]     ack_level_i,
  output logic [LW-1:0]     irq_level_o,
  output logic [TW-1:0]     irq_trap_o
);
  logic [VW-1:0] pend_q, mask_q, clr_s, frc_s;
  logic          fen_q;
  logic [LW-1:0] lvl;

  irq_regs #(.NSRC(NSRC), .DW(DW), .FEN_BIT(FEN_BIT)) u_regs (
    .clk_i, .rst_ni, .bus_wr_i, .bus_addr_i, .bus_wdata_i,
    .pend_i(pend_q), .mask_o(mask_q), .fen_o(fen_q),
    .clr_o(clr_s), .frc_o(frc_s), .rdata_o(bus_rdata_o)
  );

  irq_pend #(.NSRC(NSRC)) u_pend (
    .clk_i, .rst_ni, .req_i(src_req_i), .clr_i(clr_s), .frc_i(frc_s),
    .ack_i, .ack_level_i, .pend_o(pend_q)
  );

  irq_arb #(.NSRC(NSRC)) u_arb (.pend_i(pend_q), .mask_i(mask_q), .level_o(lvl));

  assign irq_level_o = lvl;
  assign irq_trap_o  = (lvl == '0) ? '0 : TW'(TRAP_BASE) + TW'(lvl);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int NSRC = 15,
  parameter int DW   = 32,
  parameter int TW   = 8,
  localparam int VW  = NSRC + 1,
  localparam int LW  = $clog2(NSRC + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [VW-1:0]     src_req_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic              ack_i,
  input logic [LW-1:0]     ack_level_i,
  input logic [VW-1:0]     pend_q,
  input logic [VW-1:0]     mask_q,
  input logic              fen_q,
  input logic [LW-1:0]     irq_level_o,
  input logic [TW-1:0]     irq_trap_o
);
  localparam logic [VW-1:0] SRC_M = {{NSRC{1'b1}}, 1'b0};

  a_r2_req_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((pend_q & $past(src_req_i & SRC_M)) == $past(src_req_i & SRC_M)));

  a_r4_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~mask_q & SRC_M) == '0) |-> (irq_level_o == '0));

  a_r5_level_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0) |-> (pend_q[irq_level_o] && !mask_q[irq_level_o]));

  a_r6_trap_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0) |-> (irq_trap_o == TW'(8'h10) + TW'(irq_level_o)));

  a_r7_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_CLR) |=>
      ((pend_q & $past(bus_wdata_i[VW-1:0] & ~src_req_i)) == '0));

  a_r8_force_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_FRC && !fen_q && (src_req_i & SRC_M) == '0) |=>
      ((pend_q & ~$past(pend_q)) == '0));

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_level_i != '0 && !src_req_i[ack_level_i] &&
     !(bus_wr_i && bus_addr_i == A_FRC)) |=> !pend_q[$past(ack_level_i)]);

  a_r3_bit0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |-> !pend_q[0]);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.NSRC(NSRC), .DW(DW), .TW(TW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_req_i(src_req_i), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .ack_i(ack_i),
  .ack_level_i(ack_level_i), .pend_q(pend_q), .mask_q(mask_q), .fen_q(fen_q),
  .irq_level_o(irq_level_o), .irq_trap_o(irq_trap_o)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/100ps
module sim_prio_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src_req_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        ack_i = 1'b0;
  logic [3:0]  ack_level_i = '0;
  logic [3:0]  irq_level_o;
  logic [7:0]  irq_trap_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] e_pend = '0, e_mask = 16'hFFFE;
  logic        e_fen = 1'b0;

  always #2.5 clk_i = ~clk_i;

  prio_irq_ctrl u0 (.*);

  function automatic logic [3:0] f_level(logic [15:0] p, logic [15:0] m);
    logic [3:0] l = '0;
    for (int i = 1; i < 16; i++) if (p[i] && !m[i]) l = 4'(i);
    return l;
  endfunction

  function automatic logic [7:0] f_trap(logic [3:0] l);
    return (l == 0) ? 8'h00 : 8'h10 + {4'h0, l};
  endfunction

  function automatic logic [31:0] f_rd(logic [2:0] a);
    case (a)
      3'd0: return {16'h0, e_pend};
      3'd1: return {16'h0, e_mask};
      3'd4: return {12'h0, e_fen, 19'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [15:0] req, logic wr, logic [2:0] a, logic [31:0] wd,
                     logic ak, logic [3:0] al, string tag);
    logic [15:0] clr, frc, ackb, np, nm;
    logic nf;
    @(negedge clk_i);
    src_req_i = req; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd;
    ack_i = ak; ack_level_i = al;
    clr  = (wr && a == 3'd2) ? wd[15:0] : 16'h0;
    frc  = (wr && a == 3'd3 && e_fen) ? wd[15:0] : 16'h0;
    ackb = (ak && al != 0) ? (16'h1 << al) : 16'h0;
    np   = ((e_pend & ~clr & ~ackb) | req | frc) & 16'hFFFE;
    nm   = (wr && a == 3'd1) ? (wd[15:0] & 16'hFFFE) : e_mask;
    nf   = (wr && a == 3'd4) ? wd[19] : e_fen;
    @(posedge clk_i);
    #1;
    e_pend = np; e_mask = nm; e_fen = nf;
    check("R5 level", {28'h0, irq_level_o}, {28'h0, f_level(e_pend, e_mask)});
    check("R6 trap", {24'h0, irq_trap_o}, {24'h0, f_trap(f_level(e_pend, e_mask))});
    if (!wr) check(tag, bus_rdata_o, f_rd(a));
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #12;
    check("R1 level", {28'h0, irq_level_o}, 32'h0);
    check("R1 trap", {24'h0, irq_trap_o}, 32'h0);
    rst_ni = 1'b1;
    cyc(16'h0, 0, 3'd0, 0, 0, 0, "R1 pend");
    cyc(16'h0, 0, 3'd1, 0, 0, 0, "R1 mask");
    cyc(16'h0, 0, 3'd4, 0, 0, 0, "R1 tctl");
    // latching and masking
    cyc(16'h0020, 0, 3'd0, 0, 0, 0, "R2 set");
    cyc(16'h0001, 0, 3'd0, 0, 0, 0, "R2 held, R3 bit0");
    cyc(16'h0, 1, 3'd1, 32'hFFFF_0001, 0, 0, "R4");
    cyc(16'h0, 0, 3'd1, 0, 0, 0, "R4 mask read");
    cyc(16'h1008, 0, 3'd0, 0, 0, 0, "R5 pick 12");
    cyc(16'h0, 1, 3'd1, 32'h1000, 0, 0, "R4");
    cyc(16'h0, 0, 3'd0, 0, 0, 0, "R3 masked visible");
    cyc(16'h0, 1, 3'd2, 32'h0020, 0, 0, "R7");
    cyc(16'h0, 0, 3'd0, 0, 0, 0, "R7 others kept");
    // force gating
    cyc(16'h0, 1, 3'd3, 32'h4000, 0, 0, "R8");
    cyc(16'h0, 0, 3'd0, 0, 0, 0, "R8 force blocked");
    cyc(16'h0, 1, 3'd4, 32'h0008_0000, 0, 0, "R8");
    cyc(16'h0, 0, 3'd4, 0, 0, 0, "R8 enable read");
    cyc(16'h0, 1, 3'd3, 32'h4000, 0, 0, "R8");
    cyc(16'h0, 0, 3'd0, 0, 0, 0, "R8 forced 14");
    // acknowledge
    cyc(16'h0, 0, 3'd0, 0, 1, 4'd14, "R9 ack 14");
    cyc(16'h0, 0, 3'd0, 0, 1, 4'd0, "R9 ack 0 ignored");
    // collisions
    cyc(16'h0008, 1, 3'd2, 32'h0008, 0, 0, "R10");
    cyc(16'h0, 0, 3'd0, 0, 0, 0, "R10 req vs clear");
    cyc(16'h0008, 0, 3'd0, 0, 1, 4'd3, "R10 req vs ack");
    // map
    cyc(16'h0, 1, 3'd0, 32'hFFFF_FFFF, 0, 0, "R11");
    cyc(16'h0, 0, 3'd0, 0, 0, 0, "R11 pend not writable");
    cyc(16'h0, 0, 3'd2, 0, 0, 0, "R11 clear reads 0");
    cyc(16'h0, 0, 3'd3, 0, 0, 0, "R11 force reads 0");
    cyc(16'h0, 1, 3'd4, 32'hFFFF_FFFF, 0, 0, "R11");
    cyc(16'h0, 0, 3'd4, 0, 0, 0, "R11 tctl one bit");
    cyc(16'h0, 0, 3'd7, 0, 0, 0, "R11 hole reads 0");
    // extremes
    cyc(16'h0, 1, 3'd1, 32'h0, 0, 0, "R4");
    cyc(16'h8002, 0, 3'd0, 0, 0, 0, "R5 source 15");
    cyc(16'h0, 1, 3'd2, 32'hFFFC, 0, 0, "R7");
    cyc(16'h0, 0, 3'd0, 0, 0, 0, "R6 source 1");
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [15:0] rq;
      int op;
      rq = 16'($urandom & $urandom & $urandom) & 16'hFFFE;
      if (($urandom % 3) != 0) rq = '0;
      op = int'($urandom % 8);
      case (op)
        0: cyc(rq, 1, 3'd2, $urandom, 0, 0, "R7");
        1: cyc(rq, 1, 3'd3, $urandom, 0, 0, "R8");
        2: cyc(rq, 1, 3'd1, $urandom & $urandom, 0, 0, "R4");
        3: cyc(rq, 1, 3'd4, $urandom, 0, 0, "R8");
        4: cyc(rq, 0, 3'd0, 0, 1, f_level(e_pend, e_mask), "R9 random ack");
        default: cyc(rq, 0, 3'($urandom), 0, 0, 0, "R3 random read");
      endcase
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule